// File: doc/BRIEF.md
# Translation Table Probe Engine

This block resolves one virtual address against a direct-mapped translation cache held in ordinary memory. The table has a power-of-two number of 16-byte slots. Each slot holds a 64-bit tag word at offset 0 and a 64-bit page table entry at offset 8. For each request the engine forms a comparison tag from the address space context and the upper virtual address bits. It locates the slot from the table base and the low page-number bits, and reads the tag word. Only when that word matches does it read the entry word as well.

No separate valid bit exists. An all-zero stored tag marks an empty slot. Software that updates a slot sets bit 47 of the stored tag while it works, and any such tag is refused. The engine handles one lookup at a time and ignores new requests until the current one has finished. It reports the outcome as a one-cycle result: hit with the entry, or miss.

Top module: `tsb_probe`

## Requirements
- R1: After reset `busy`, `done`, `hit`, `miss` and `mem_req` are all low.
- R2: The comparison tag is `{3'b000, ctx[12:0], 6'b000000, vaddr[63:22]}`, so the context sits in bits 60:48 and the upper address bits in 41:0.
- R3: The tag read goes to `TABLE_BASE + 16 * ((vaddr >> PAGE_SHIFT) & (ENTRIES-1))`. The entry read goes to that address plus 8. Every read address is 8-byte aligned and lies inside the table.
- R4: When the stored tag equals the comparison tag, the engine reads the entry word and reports `done` together with `hit`, with `pte` equal to that word.
- R5: When the stored tag differs, the engine reports `done` with `miss` and `pte` zero after a single read, with no entry read.
- R6: A stored tag with bit 47 set always yields a miss.
- R7: A stored tag of all zeros always yields a miss, even when the computed tag is zero (context 0, `vaddr[63:22]` zero).
- R8: `mem_req` stays high with `mem_addr` unchanged until `mem_gnt` is seen. `mem_rdata` is taken in the cycle of the grant.
- R9: `busy` rises the cycle after an accepted `start` and falls in the cycle `done` is high. A `start` while busy is ignored and produces no extra result and no change of address.
- R10: `done` lasts one cycle, and in that cycle exactly one of `hit` and `miss` is high. Neither is high outside it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup when idle |
| vaddr | input | 64 | Virtual address to translate |
| ctx | input | 13 | Address space context |
| busy | output | 1 | Lookup in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Byte address of the 64-bit read |
| mem_gnt | input | 1 | Read accepted, data valid this cycle |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | Result valid pulse |
| hit | output | 1 | Lookup found a matching slot |
| miss | output | 1 | Lookup found no usable slot |
| pte | output | 64 | Entry word on hit, zero on miss |

## Verification
The bench builds the engine with 16 entries, 8 KiB pages and a non-zero table base. With so few slots, two addresses that share index bits but differ in upper bits collide after a handful of requests, so aliasing misses are reached directly. The small table also lets every slot be loaded with its own matching tag and swept, alongside locked, empty and all-ones-field slots. Grant latency cycles between zero and two waits, so held requests and back-to-back grants both occur.

// File: rtl/tsb_probe.sv
module tsb_probe #(
  parameter logic [63:0] TABLE_BASE = 64'h0,
  parameter int ENTRIES  = 2048,
  parameter int PAGE_SHIFT = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] vaddr,
  input  logic [12:0] ctx,
  output logic        busy,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_gnt,
  input  logic [63:0] mem_rdata,
  output logic        done,
  output logic        hit,
  output logic        miss,
  output logic [63:0] pte
);
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int LOCK_BIT = 47;
  localparam logic [63:0] TABLE_END = TABLE_BASE + 64'(ENTRIES) * 64'd16;

  typedef enum logic [1:0] {S_IDLE, S_TAG, S_PTE} state_t;

  state_t      state;
  logic [63:0] want_tag;
  logic [63:0] slot_addr;
  logic [IDX_W-1:0] idx;
  logic        tag_ok;

  assign idx     = vaddr[PAGE_SHIFT +: IDX_W];
  assign busy    = (state != S_IDLE);
  assign mem_req = busy;
  assign mem_addr = (state == S_PTE) ? slot_addr + 64'd8 : slot_addr;
  assign tag_ok  = (mem_rdata == want_tag) && (mem_rdata != 64'd0) && !mem_rdata[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      want_tag  <= '0;
      slot_addr <= TABLE_BASE;
      done      <= 1'b0;
      hit       <= 1'b0;
      miss      <= 1'b0;
      pte       <= '0;
    end else begin
      done <= 1'b0;
      hit  <= 1'b0;
      miss <= 1'b0;
      pte  <= '0;
      case (state)
        S_IDLE: if (start) begin
          want_tag  <= {3'b000, ctx, 6'b000000, vaddr[63:22]};
          slot_addr <= TABLE_BASE + ({{(64-IDX_W){1'b0}}, idx} << 4);
          state     <= S_TAG;
        end
        S_TAG: if (mem_gnt) begin
          if (tag_ok) begin
            state <= S_PTE;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
            miss  <= 1'b1;
          end
        end
        S_PTE: if (mem_gnt) begin
          state <= S_IDLE;
          done  <= 1'b1;
          hit   <= 1'b1;
          pte   <= mem_rdata;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr >= TABLE_BASE) && (mem_addr < TABLE_END) && (mem_addr[2:0] == 3'b000));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  result_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || miss) |-> done && (hit != miss));

  // R5
  miss_pte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> pte == 64'd0);

  // R9
  busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  // R6
  lock_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TAG) && mem_gnt && mem_rdata[LOCK_BIT] |=> miss);

  // R7
  empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TAG) && mem_gnt && (mem_rdata == 64'd0) |=> miss);
endmodule

// File: tb/test_tsb_probe.sv
`timescale 1ns/1ps
module test_tsb_probe;
  localparam logic [63:0] BASE = 64'h0000_0000_0040_0000;
  localparam int N  = 16;
  localparam int PS = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] vaddr = '0;
  logic [12:0] ctx = '0;
  logic busy, mem_req, done, hit, miss;
  logic [63:0] mem_addr, pte;
  logic mem_gnt = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  tsb_probe #(.TABLE_BASE(BASE), .ENTRIES(N), .PAGE_SHIFT(PS)) i_tsb_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .ctx(ctx),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .done(done), .hit(hit), .miss(miss), .pte(pte));

  typedef struct { logic h; logic [63:0] p; int reads; } exp_t;
  exp_t q[$];
  logic [63:0] tbl_tag [N];
  logic [63:0] tbl_pte [N];
  int checks = 0, errors = 0;
  int nreads = 0;
  int wait_left = 0, dseed = 0;
  bit pend = 0, finished = 0;
  logic [63:0] held = '0, exp_slot = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_tag(input logic [12:0] c, input logic [63:0] va);
    return {3'b000, c, 6'b000000, va[63:22]};
  endfunction

  function automatic logic [63:0] mk_va(input logic [41:0] hi, input int idx);
    return ({hi, 22'd0}) | (64'(idx) << PS) | 64'h123;
  endfunction

  // memory model: grant after 0..2 waits, addresses checked against expected slot
  always @(negedge clk) begin
    mem_gnt = 1'b0;
    if (rst_n && mem_req) begin
      if (pend) chk(mem_addr == held, "R8", "address held", mem_addr, held);
      chk(mem_addr == (mem_addr[3] ? exp_slot + 64'd8 : exp_slot), "R3", "read address",
          mem_addr, mem_addr[3] ? exp_slot + 64'd8 : exp_slot);
      if (wait_left == 0) begin
        int s;
        s = int'((mem_addr - BASE) >> 4) % N;
        mem_gnt = 1'b1;
        mem_rdata = mem_addr[3] ? tbl_pte[s] : tbl_tag[s];
        nreads++;
        wait_left = dseed % 3;
        dseed++;
        pend = 1'b0;
      end else begin
        wait_left--;
        pend = 1'b1;
        held = mem_addr;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9", "unexpected result", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(hit == e.h, e.h ? "R4" : "R5", "hit", 64'(hit), 64'(e.h));
        chk(miss == !e.h, "R10", "miss", 64'(miss), 64'(!e.h));
        chk(pte == e.p, e.h ? "R4" : "R5", "pte", pte, e.p);
        chk(nreads == e.reads, "R5", "read count", 64'(nreads), 64'(e.reads));
      end
      nreads = 0;
    end
  end

  task automatic lookup(input logic [63:0] va, input logic [12:0] c, input bit poke);
    exp_t e;
    int idx;
    idx = int'(va[PS +: 4]);
    e.h = (tbl_tag[idx] != 0) && (tbl_tag[idx] == mk_tag(c, va));
    e.p = e.h ? tbl_pte[idx] : 64'd0;
    e.reads = e.h ? 2 : 1;
    q.push_back(e);
    exp_slot = BASE + 64'(idx) * 64'd16;
    chk(busy == 1'b0, "R9", "idle before start", 64'(busy), 64'd0);
    vaddr = va; ctx = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
    if (poke) begin
      vaddr = va ^ (64'h5 << PS); ctx = c + 13'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      tbl_tag[i] = mk_tag(13'(i + 1), mk_va(42'(i + 100), i));
      tbl_pte[i] = 64'hA000_0000_0000_0000 | 64'(i * 37 + 5);
    end
    tbl_tag[0] = 64'd0;
    tbl_tag[2] = mk_tag(13'd7, mk_va(42'd9, 2)) | (64'd1 << 47);
    tbl_tag[4] = mk_tag(13'h1FFF, mk_va(42'h3FF_FFFF_FFFF, 4));
    tbl_pte[4] = 64'hFFFF_0000_DEAD_BEEF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !hit && !miss && !mem_req, "R1", "reset outputs",
        {59'd0, busy, done, hit, miss, mem_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: sweep every matching slot
    for (int i = 1; i < N; i++)
      if (i != 2 && i != 4) lookup(mk_va(42'(i + 100), i), 13'(i + 1), 1'b0);
    // R2: all-ones context and upper address bits
    lookup(mk_va(42'h3FF_FFFF_FFFF, 4), 13'h1FFF, 1'b0);
    // R2: context differs by one bit
    lookup(mk_va(42'h3FF_FFFF_FFFF, 4), 13'h1FFE, 1'b0);
    // R5: aliasing address, same index, other upper bits
    lookup(mk_va(42'd104, 3), 13'd4, 1'b0);
    // R6: locked slot that otherwise matches
    lookup(mk_va(42'd9, 2), 13'd7, 1'b0);
    // R7: empty slot against an all-zero computed tag
    lookup(64'd0, 13'd0, 1'b0);
    lookup(mk_va(42'd0, 0), 13'd1, 1'b0);
    // R9: start while busy ignored, on hit and on miss
    lookup(mk_va(42'd106, 6), 13'd7, 1'b1);
    lookup(mk_va(42'd500, 7), 13'd8, 1'b1);
    // R4: unlock slot 2 and retry
    tbl_tag[2] = mk_tag(13'd7, mk_va(42'd9, 2));
    lookup(mk_va(42'd9, 2), 13'd7, 1'b0);
    // R10: no stray result afterwards
    repeat (5) @(negedge clk);
    chk(!done && !hit && !miss, "R10", "quiet when idle", {61'd0, done, hit, miss}, 64'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule